// File: doc/BRIEF.md
# Peripheral card address decoder with wait-state trap

This block is the glue logic of a floppy-controller expansion card that sits on a host bus with a 16-bit address and byte-wide data. From the current host address it raises one of four select strobes: the serial-bit I/O port, a small scratch RAM, the disk-controller register file, or a two-page firmware ROM. It also forms the ROM page address, the scratch RAM address and the controller register index. Because the RAM keeps only four bits per entry, the block passes the upper data nibble to the RAM and returns that nibble with the low nibble zero.

Firmware reads the controller data register in a tight loop while a sector streams in. To keep that loop short, the block can pull the host READY line low. This inserts wait states until the controller either presents a byte or signals completion. The trap applies only when software has enabled it and the drive motor is running.

A parameter picks between two board generations. The revised one has a narrower serial-port window. It also splits controller reads and writes by address bit 3 and lets odd controller addresses fall through to the ROM. All decode paths are combinational. The clock and reset feed only the embedded property checks.

Top module: `card_addr_decode`

## Requirements
- R1: `sio_sel` is 1 exactly when (addr & 0xFF80) == 0x1100 with REVISED=0, or when (addr & 0xFFC0) == 0x1100 with REVISED=1. It does not depend on `card_en`.
- R2: `ram_sel` is 1 exactly when `card_en`=1, (addr & 0xFF80) == 0x4000 and `bank_hi`=1. `ram_addr` equals addr[6:0].
- R3: `ram_wnib` equals wdata[7:4]. `ram_rbyte` equals {ram_rnib, 4'b0000}.
- R4: `fdc_sel` is 1 exactly when `card_en`=1, (addr & 0xFF80) == 0x5F80 and addr[0]=0. With REVISED=1, addr[3] must also equal `wr`, so writes use 0x5FF8..0x5FFE and reads use 0x5FF0..0x5FF6.
- R5: `fdc_reg` equals addr[2:1].
- R6: `rom_sel` is 1 exactly when `card_en`=1, addr[15:13] == 3'b010 and `ram_sel`=0, and also:
  - with REVISED=0, addr is outside the controller window (0x5F80..0x5FFF);
  - with REVISED=1, `fdc_sel`=0.
- R7: `rom_addr` equals {bank_hi, addr[12:0]}. Page 0 is the lower 8 KiB and page 1 the upper 8 KiB.
- R8: At most one of `ram_sel`, `fdc_sel` and `rom_sel` is 1 at any time.
- R9: With REVISED=0, `ready` is 0 exactly when all of the following hold:
  - `card_en`=1, (addr & 0xFF80) == 0x5F80 and (addr & 7) == 6;
  - `trap_en`=1 and `motor_on`=1;
  - `drq`=0 and `intrq`=0.
- R10: With REVISED=1, `ready` is 0 exactly when all of the following hold:
  - `card_en`=1, (addr & 0xFF80) == 0x5F80, addr[0]=0 and (addr & 6) == 6;
  - `trap_en`=1 and `motor_on`=1;
  - `drq`=0 and `intrq`=0.
- R11: `ready` returns to 1 in the same cycle that `drq` or `intrq` rises, with no register in the path.
- R12: With `card_en`=0, `ram_sel`, `fdc_sel` and `rom_sel` are 0 and `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the embedded property checks |
| rst_n | input | 1 | Active-low reset that disables the property checks |
| addr | input | 16 | Host address |
| wr | input | 1 | 1 for a host write, 0 for a read |
| card_en | input | 1 | Card enable bit from the serial I/O port |
| bank_hi | input | 1 | Upper ROM page bit, also gates the RAM |
| trap_en | input | 1 | Wait-state trap enable |
| drq | input | 1 | Controller data request |
| intrq | input | 1 | Controller completion interrupt |
| motor_on | input | 1 | Drive motor running |
| wdata | input | 8 | Host write data |
| ram_rnib | input | 4 | Nibble read from the scratch RAM |
| sio_sel | output | 1 | Serial-bit I/O port select |
| ram_sel | output | 1 | Scratch RAM select |
| fdc_sel | output | 1 | Controller register select |
| rom_sel | output | 1 | Firmware ROM select |
| rom_addr | output | 14 | ROM address including the page bit |
| ram_addr | output | 7 | Scratch RAM address |
| fdc_reg | output | 2 | Controller register index |
| ram_wnib | output | 4 | Nibble to write into the scratch RAM |
| ram_rbyte | output | 8 | RAM read data widened to a byte |
| ready | output | 1 | Host READY, low inserts a wait state |

## Verification
Every output of this block is combinational, so each result is due in the same cycle as the input change that causes it. The bench drives all inputs just after a falling clock edge. It samples one nanosecond later, well before the next rising edge. For READY recovery, the bench raises only `drq` or only `intrq` between two samples taken inside one clock period. This shows that no register stands in that path.

// File: rtl/card_addr_decode.sv
module card_addr_decode #(
  parameter bit REVISED = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        wr,
  input  logic        card_en,
  input  logic        bank_hi,
  input  logic        trap_en,
  input  logic        drq,
  input  logic        intrq,
  input  logic        motor_on,
  input  logic [7:0]  wdata,
  input  logic [3:0]  ram_rnib,
  output logic        sio_sel,
  output logic        ram_sel,
  output logic        fdc_sel,
  output logic        rom_sel,
  output logic [13:0] rom_addr,
  output logic [6:0]  ram_addr,
  output logic [1:0]  fdc_reg,
  output logic [3:0]  ram_wnib,
  output logic [7:0]  ram_rbyte,
  output logic        ready
);
  localparam logic [15:0] SIO_MASK = REVISED ? 16'hFFC0 : 16'hFF80;
  localparam logic [15:0] SIO_BASE = 16'h1100;
  localparam logic [15:0] BLK_MASK = 16'hFF80;
  localparam logic [15:0] RAM_BASE = 16'h4000;
  localparam logic [15:0] FDC_BASE = 16'h5F80;

  logic ram_win, fdc_win, rom_win, fdc_rw_ok, wait_hit;

  assign sio_sel  = (addr & SIO_MASK) == SIO_BASE;
  assign ram_win  = card_en && ((addr & BLK_MASK) == RAM_BASE);
  assign fdc_win  = card_en && ((addr & BLK_MASK) == FDC_BASE);
  assign rom_win  = card_en && (addr[15:13] == 3'b010);

  assign fdc_rw_ok = REVISED ? (addr[3] == wr) : 1'b1;
  assign ram_sel   = ram_win && bank_hi;
  assign fdc_sel   = fdc_win && !addr[0] && fdc_rw_ok;
  assign rom_sel   = rom_win && !ram_sel && !(REVISED ? fdc_sel : fdc_win);

  assign rom_addr  = {bank_hi, addr[12:0]};
  assign ram_addr  = addr[6:0];
  assign fdc_reg   = addr[2:1];
  assign ram_wnib  = wdata[7:4];
  assign ram_rbyte = {ram_rnib, 4'b0000};

  generate
    if (REVISED) begin : g_rev_trap
      logic trap_term;
      assign trap_term = trap_en && (addr[2:1] == 2'b11) && motor_on;
      assign wait_hit  = fdc_win && !addr[0] && trap_term;
    end else begin : g_orig_trap
      assign wait_hit  = fdc_win && (addr[2:0] == 3'd6) && trap_en && motor_on;
    end
  endgenerate

  assign ready = !(wait_hit && !drq && !intrq);

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_sel, fdc_sel, rom_sel}));

  assert_wait_needs_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!drq && !intrq && motor_on && trap_en && card_en));

  assert_disabled_card_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !card_en |-> (ready && !ram_sel && !fdc_sel && !rom_sel));

  assert_nibble_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel |-> (ram_rbyte[3:0] == 4'b0000));

  assert_rom_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (rom_addr[13] == bank_hi));

  assert_sio_apart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sio_sel |-> (!ram_sel && !fdc_sel && !rom_sel));
endmodule

// File: tb/card_addr_decode_tb.sv
module card_addr_decode_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] addr;
  logic wr, card_en, bank_hi, trap_en, drq, intrq, motor_on;
  logic [7:0] wdata;
  logic [3:0] ram_rnib;

  logic o_sio, o_ram, o_fdc, o_rom, o_rdy;
  logic [13:0] o_rom_a;
  logic [6:0] o_ram_a;
  logic [1:0] o_reg;
  logic [3:0] o_wnib;
  logic [7:0] o_rbyte;
  logic r_sio, r_ram, r_fdc, r_rom, r_rdy;
  logic [13:0] r_rom_a;
  logic [6:0] r_ram_a;
  logic [1:0] r_reg;
  logic [3:0] r_wnib;
  logic [7:0] r_rbyte;

  card_addr_decode #(.REVISED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .card_en(card_en),
    .bank_hi(bank_hi), .trap_en(trap_en), .drq(drq), .intrq(intrq),
    .motor_on(motor_on), .wdata(wdata), .ram_rnib(ram_rnib),
    .sio_sel(o_sio), .ram_sel(o_ram), .fdc_sel(o_fdc), .rom_sel(o_rom),
    .rom_addr(o_rom_a), .ram_addr(o_ram_a), .fdc_reg(o_reg),
    .ram_wnib(o_wnib), .ram_rbyte(o_rbyte), .ready(o_rdy));

  card_addr_decode #(.REVISED(1'b1)) u_rev (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .card_en(card_en),
    .bank_hi(bank_hi), .trap_en(trap_en), .drq(drq), .intrq(intrq),
    .motor_on(motor_on), .wdata(wdata), .ram_rnib(ram_rnib),
    .sio_sel(r_sio), .ram_sel(r_ram), .fdc_sel(r_fdc), .rom_sel(r_rom),
    .rom_addr(r_rom_a), .ram_addr(r_ram_a), .fdc_reg(r_reg),
    .ram_wnib(r_wnib), .ram_rbyte(r_rbyte), .ready(r_rdy));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  function automatic bit e_sio(bit rev);
    if (rev) return addr >= 16'h1100 && addr <= 16'h113F;
    return addr >= 16'h1100 && addr <= 16'h117F;
  endfunction
  function automatic bit in_ctl();
    return addr >= 16'h5F80 && addr <= 16'h5FFF;
  endfunction
  function automatic bit e_ram();
    return card_en && bank_hi && addr >= 16'h4000 && addr <= 16'h407F;
  endfunction
  function automatic bit e_fdc(bit rev);
    if (!card_en || !in_ctl() || addr[0]) return 1'b0;
    if (rev && (addr[3] != wr)) return 1'b0;
    return 1'b1;
  endfunction
  function automatic bit e_rom(bit rev);
    bit blocked;
    if (!card_en || addr < 16'h4000 || addr > 16'h5FFF) return 1'b0;
    blocked = rev ? e_fdc(1'b1) : in_ctl();
    return !(blocked || e_ram());
  endfunction
  function automatic bit e_rdy(bit rev);
    bit low_bits;
    low_bits = rev ? (addr[2:0] == 3'b110) : (addr[2:0] == 3'b110);
    if (card_en && in_ctl() && low_bits && trap_en && motor_on && !drq && !intrq)
      return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_all();
    chk("R1 sio", {15'd0, o_sio}, {15'd0, e_sio(1'b0)});
    chk("R1 sio rev", {15'd0, r_sio}, {15'd0, e_sio(1'b1)});
    chk("R2 ram_sel", {14'd0, r_ram, o_ram}, {14'd0, e_ram(), e_ram()});
    chk("R2 ram_addr", {9'd0, o_ram_a}, {9'd0, addr[6:0]});
    chk("R3 ram_wnib", {12'd0, o_wnib}, {12'd0, wdata[7:4]});
    chk("R3 ram_rbyte", {8'd0, r_rbyte}, {8'd0, ram_rnib, 4'h0});
    chk("R4 fdc_sel", {15'd0, o_fdc}, {15'd0, e_fdc(1'b0)});
    chk("R4 fdc_sel rev", {15'd0, r_fdc}, {15'd0, e_fdc(1'b1)});
    chk("R5 fdc_reg", {14'd0, r_reg}, {14'd0, addr[2:1]});
    chk("R6 rom_sel", {15'd0, o_rom}, {15'd0, e_rom(1'b0)});
    chk("R6 rom_sel rev", {15'd0, r_rom}, {15'd0, e_rom(1'b1)});
    chk("R7 rom_addr", {2'd0, o_rom_a}, {2'd0, bank_hi, addr[12:0]});
    chk("R8 one target", {15'd0, ($countones({o_ram, o_fdc, o_rom}) > 1)}, 16'd0);
    chk("R9 ready", {15'd0, o_rdy}, {15'd0, e_rdy(1'b0)});
    chk("R10 ready rev", {15'd0, r_rdy}, {15'd0, e_rdy(1'b1)});
    if (!card_en)
      chk("R12 disabled", {12'd0, o_ram | r_ram, o_fdc | r_fdc, o_rom | r_rom, o_rdy & r_rdy},
          16'h0001);
  endtask

  task automatic apply(input logic [15:0] a, input bit w, input bit ce, input bit bh,
                       input bit te, input bit d, input bit i, input bit m);
    @(negedge clk);
    addr = a; wr = w; card_en = ce; bank_hi = bh; trap_en = te;
    drq = d; intrq = i; motor_on = m;
    wdata = 8'($urandom); ram_rnib = 4'($urandom);
    #1;
    check_all();
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 6)
      0: return 16'h1100 | 16'($urandom % 128);
      1: return 16'h4000 | 16'($urandom % 256);
      2: return 16'h5F80 | 16'($urandom % 128);
      3: return 16'h4000 | 16'($urandom % 8192);
      4: return 16'h5FF0 | 16'($urandom % 16);
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    addr = 16'h0000; wr = 0; card_en = 0; bank_hi = 0; trap_en = 0;
    drq = 0; intrq = 0; motor_on = 0; wdata = 8'h00; ram_rnib = 4'h0;
    #1;
    check_all();  // reset state, R12
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    apply(16'h1100, 0, 0, 0, 0, 0, 0, 0);  // R1 without card enable
    apply(16'h1150, 0, 1, 0, 0, 0, 0, 0);  // R1 differs between variants
    apply(16'h4000, 1, 1, 1, 0, 0, 0, 0);  // R2 RAM selected
    apply(16'h407F, 0, 1, 0, 0, 0, 0, 0);  // R2 bank low: ROM instead
    apply(16'h4080, 0, 1, 1, 0, 0, 0, 0);  // R6 just past RAM
    apply(16'h5FF4, 0, 1, 0, 0, 0, 0, 0);  // R4 read address
    apply(16'h5FFC, 1, 1, 0, 0, 0, 0, 0);  // R4 write address
    apply(16'h5FFC, 0, 1, 0, 0, 0, 0, 0);  // R4 revised rejects read at write slot
    apply(16'h5FF5, 0, 1, 0, 0, 0, 0, 0);  // R6 odd controller address
    apply(16'h5F7F, 0, 1, 1, 0, 0, 0, 0);  // R7 upper page, top of ROM
    apply(16'h5FF6, 0, 1, 0, 1, 0, 0, 1);  // R9 R10 wait
    apply(16'h5FF7, 0, 1, 0, 1, 0, 0, 1);  // R9 odd address no wait
    apply(16'h5FFE, 0, 1, 0, 1, 0, 0, 1);  // R10 wait at 0x5FFE
    apply(16'h5FF6, 0, 1, 0, 1, 0, 0, 0);  // motor off: no wait
    apply(16'h5FF6, 0, 1, 0, 0, 0, 0, 1);  // trap disabled: no wait
    apply(16'h5FF6, 0, 0, 0, 1, 0, 0, 1);  // R12 card off

    // R11: recovery in the same cycle
    apply(16'h5FF6, 0, 1, 0, 1, 0, 0, 1);
    drq = 1'b1; #1;
    chk("R11 drq recovery", {14'd0, r_rdy, o_rdy}, 16'h0003);
    drq = 1'b0; #1;
    chk("R11 wait again", {14'd0, r_rdy, o_rdy}, 16'h0000);
    intrq = 1'b1; #1;
    chk("R11 intrq recovery", {14'd0, r_rdy, o_rdy}, 16'h0003);

    for (int n = 0; n < 400; n++)
      apply(pick_addr(), 1'($urandom), ($urandom % 4) != 0, 1'($urandom), 1'($urandom),
            ($urandom % 3) == 0, ($urandom % 4) == 0, ($urandom % 4) != 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule